// File: doc/BRIEF.md
# SPI Controller with Wake-Line Readiness Handshake

This block is an SPI controller that gets the target's consent before it clocks anything. The consent comes over a single shared wake line with a pull-up. While idle, the controller holds the line low through an output enable. When a transfer is requested, it stops driving the line and the pull-up raises it. The target prepares itself and then pulls the line low. The controller treats that high-to-low change, seen while the line is released, as permission to assert chip select and run the transfer.

The transfer is full duplex, SPI mode 0, most significant bit first. Separate transmit and receive byte counts are given with the request. The transfer runs for the larger of the two counts:

- Once the transmit bytes are used up, a fixed filler byte is shifted out in their place.
- Bytes received past the receive count are dropped.

After chip select is released, the controller waits for the target to let go of the wake line. It then drives the line low again and reports completion. If the target never answers within a parameterized number of cycles, the request ends with an error flag and chip select is never asserted.

Top module: `spi_wake_master`

## Requirements
- R1: After reset, `wake_oe` is 1 (the line is driven low), `cs_n` is 1, `sclk` is 0, and `busy` and `done` are 0. `sclk` stays low whenever `cs_n` is high.
- R2: A `start` seen in idle with a nonzero length is accepted. One clock later `busy` is 1 and `wake_oe` is 0, while `cs_n` is still 1. `cs_n` goes low only while `wake_oe` is 0.
- R3: `cs_n` goes low only after the synchronized wake input has been seen high and then low following the release. A line that is still held low from before the request does not count as ready.
- R4: If readiness has not arrived `WAIT_LIMIT` cycles after acceptance, the controller does the following, and `cs_n` never goes low:
  - it pulses `done` with `timeout_err` at 1;
  - it drives the wake line low again;
  - it drops `busy`.
- R5: Data moves in SPI mode 0, most significant bit first. `mosi` changes only while `sclk` is low, and `miso` is sampled on each rising `sclk` edge.
- R6: For the first `tx_len` bytes, `tx_take` pulses once per byte, and `mosi` carries the value `tx_data` held when that byte was loaded.
- R7: Byte positions at or beyond `tx_len` shift out `FILL_BYTE`, whose default is 8'hFF.
- R8: `rx_valid` pulses exactly `rx_len` times. Each pulse carries the next received byte in order on `rx_data`. Bytes at positions at or beyond `rx_len` are discarded.
- R9: A transfer lasts max(`tx_len`, `rx_len`) bytes, at most 2^`LEN_W`-1. A `start` with both lengths 0 is ignored.
- R10: After the last byte, `cs_n` rises and the controller keeps `wake_oe` at 0 until the synchronized wake input reads high. It then sets `wake_oe` to 1 and pulses `done` for one clock. `busy` falls in the same cycle, with `timeout_err` at 0.
- R11: A `start` that arrives while `busy` is 1 is ignored. It neither changes the running transfer nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, taken in idle |
| tx_len | input | LEN_W | Number of bytes taken from the transmit stream |
| rx_len | input | LEN_W | Number of received bytes delivered |
| tx_data | input | 8 | Next transmit byte |
| tx_take | output | 1 | One-clock pulse: current `tx_data` consumed |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock pulse: `rx_data` holds a new byte |
| busy | output | 1 | High from accepted start until wake line driven low again |
| done | output | 1 | One-clock completion pulse |
| timeout_err | output | 1 | Set when the request ended without readiness; cleared on the next accepted start |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| wake_oe | output | 1 | 1 drives the wake line low, 0 releases it to the pull-up |
| wake_in | input | 1 | Level sensed on the wake line |

## Verification
Some rules are checked by the embedded properties on every clock:

- chip select is never asserted while the controller still drives the wake line;
- the serial clock stays low outside chip select;
- `mosi` holds steady during each high phase;
- an error is never flagged alongside chip select;
- idle always drives the wake line;
- `done` lasts one cycle.

Other behaviour only shows through the bench's target model and byte-level comparison:

- most-significant-first ordering and the filler substitution;
- the dropped receive bytes;
- rejection of a wake line that was already low;
- the timeout cycle count;
- waiting for the target's release before completion;
- ignoring a second request.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REL,
      ST_RDY,
      ST_SETUP,
      ST_XFER,
      ST_HOLD,
      ST_FREE
   } swm_state_e;

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("swm_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= d;
      end
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/swm_tick.sv
module swm_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (HALF < 1) begin : g_bad_half
      $error("swm_tick: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      logic          wrap;

      assign wrap = (cnt == CW'(HALF - 1));
      assign tick = run && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (!run) cnt <= '0;
         else if (wrap) cnt <= '0;
         else           cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spi_wake_master.sv
module spi_wake_master
   import spi_wake_pkg::*;
#(
   parameter int         LEN_W       = 8,
   parameter int         CLK_DIV     = 4,
   parameter int         WAIT_LIMIT  = 4096,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] FILL_BYTE   = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] tx_len,
   input  logic [LEN_W-1:0] rx_len,
   input  logic [7:0]       tx_data,
   output logic             tx_take,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   output logic             busy,
   output logic             done,
   output logic             timeout_err,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n,
   input  logic             miso,
   output logic             wake_oe,
   input  logic             wake_in
);

   localparam int HALF = CLK_DIV / 2;
   localparam int WCW  = $clog2(WAIT_LIMIT + 1);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_wake_master: CLK_DIV must be even and at least 2");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("spi_wake_master: LEN_W must be at least 1");
   end
   if (WAIT_LIMIT < 1) begin : g_bad_wait
      $error("spi_wake_master: WAIT_LIMIT must be at least 1");
   end

   swm_state_e       state;
   logic [LEN_W-1:0] tx_n, rx_n, total, byte_idx, nxt_idx;
   logic [2:0]       bit_idx;
   logic [7:0]       tx_sh, rx_sh;
   logic [WCW-1:0]   wcnt;
   logic             wake_s, tick, run, wait_over, any_len;

   swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wake_in),
      .q     (wake_s)
   );

   swm_tick #(.HALF(HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   assign run       = (state == ST_SETUP) || (state == ST_XFER) || (state == ST_HOLD);
   assign wait_over = (wcnt == WCW'(WAIT_LIMIT - 1));
   assign nxt_idx   = byte_idx + 1'b1;
   assign any_len   = (tx_len != '0) || (rx_len != '0);
   assign busy      = (state != ST_IDLE);
   assign mosi      = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         tx_n        <= '0;
         rx_n        <= '0;
         total       <= '0;
         byte_idx    <= '0;
         bit_idx     <= '0;
         tx_sh       <= '0;
         rx_sh       <= '0;
         wcnt        <= '0;
         wake_oe     <= 1'b1;
         cs_n        <= 1'b1;
         sclk        <= 1'b0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         tx_take     <= 1'b0;
         rx_valid    <= 1'b0;
         rx_data     <= '0;
      end else begin
         done     <= 1'b0;
         tx_take  <= 1'b0;
         rx_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start && any_len) begin
                  tx_n        <= tx_len;
                  rx_n        <= rx_len;
                  total       <= (tx_len > rx_len) ? tx_len : rx_len;
                  timeout_err <= 1'b0;
                  wake_oe     <= 1'b0;
                  wcnt        <= '0;
                  state       <= ST_REL;
               end
            end
            ST_REL, ST_RDY: begin
               wcnt <= wcnt + 1'b1;
               if (wait_over) begin
                  wake_oe     <= 1'b1;
                  timeout_err <= 1'b1;
                  done        <= 1'b1;
                  state       <= ST_IDLE;
               end else if (state == ST_REL) begin
                  if (wake_s) state <= ST_RDY;
               end else if (!wake_s) begin
                  cs_n     <= 1'b0;
                  byte_idx <= '0;
                  bit_idx  <= '0;
                  if (tx_n != '0) begin
                     tx_sh   <= tx_data;
                     tx_take <= 1'b1;
                  end else begin
                     tx_sh <= FILL_BYTE;
                  end
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (tick) begin
                  sclk  <= 1'b1;
                  rx_sh <= {rx_sh[6:0], miso};
                  state <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk  <= 1'b1;
                     rx_sh <= {rx_sh[6:0], miso};
                  end else begin
                     sclk <= 1'b0;
                     if (bit_idx == 3'd7) begin
                        if (byte_idx < rx_n) begin
                           rx_valid <= 1'b1;
                           rx_data  <= rx_sh;
                        end
                        if (byte_idx == total - 1'b1) begin
                           state <= ST_HOLD;
                        end else begin
                           byte_idx <= nxt_idx;
                           bit_idx  <= '0;
                           if (nxt_idx < tx_n) begin
                              tx_sh   <= tx_data;
                              tx_take <= 1'b1;
                           end else begin
                              tx_sh <= FILL_BYTE;
                           end
                        end
                     end else begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  cs_n  <= 1'b1;
                  state <= ST_FREE;
               end
            end
            ST_FREE: begin
               if (wake_s) begin
                  wake_oe <= 1'b1;
                  done    <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   cs_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !wake_oe);

   // R1
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R5
   mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R4
   err_without_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> cs_n);

   // R10
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   idle_drives_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> wake_oe);

   // R8
   rx_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !cs_n);

endmodule

// File: tb/spi_wake_master_tb.sv
`timescale 1ns/1ps
module spi_wake_master_tb;

   localparam int LW   = 4;
   localparam int WL   = 300;
   localparam int MAXB = 16;

   // {tx_len[3:0], rx_len[3:0], seed[7:0]}
   localparam logic [15:0] VECS [6] = '{16'h33A1, 16'h1427, 16'h41C5,
                                        16'h0263, 16'h2099, 16'hFF5E};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [LW-1:0] tx_len = '0, rx_len = '0;
   logic [7:0] tx_data;
   logic tx_take, rx_valid, busy, done, timeout_err, sclk, mosi, cs_n, wake_oe;
   logic [7:0] rx_data;
   logic miso = 1'b0;
   logic wake_in;

   always #10 clk = ~clk;

   int tests = 0, fails = 0;

   // bench state
   logic [7:0] cur_seed = '0;
   int tx_k, rx_cnt, mbits, done_cnt, sbit, cyc = 0, done_cyc, rel_cyc, cs_lo_seen;
   logic [7:0] mcur;
   logic [7:0] mosi_got [MAXB];
   logic [7:0] rx_got [MAXB];
   logic sclk_q = 1'b0, cs_q = 1'b1;
   // target model
   bit tgt_en = 1'b0, tgt_drive = 1'b0, pre_low = 1'b0, saw_cs = 1'b0;
   int tgt_ph = 0, tgt_cnt = 0, tgt_delay = 5, tgt_hold = 6;

   function automatic logic [7:0] txpat(input logic [7:0] s, input int i);
      return (s + 8'(i * 37)) ^ 8'hC3;
   endfunction
   function automatic logic [7:0] rxpat(input logic [7:0] s, input int i);
      return s ^ 8'(i * 53 + 11);
   endfunction

   assign tx_data = txpat(cur_seed, tx_k);
   assign wake_in = wake_oe ? 1'b0 : ~(tgt_drive | pre_low);

   spi_wake_master #(.LEN_W(LW), .CLK_DIV(4), .WAIT_LIMIT(WL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len), .rx_len(rx_len),
      .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
      .busy(busy), .done(done), .timeout_err(timeout_err), .sclk(sclk), .mosi(mosi),
      .cs_n(cs_n), .miso(miso), .wake_oe(wake_oe), .wake_in(wake_in)
   );

   // monitor and target model, away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (tx_take) tx_k = tx_k + 1;
      if (rx_valid) begin
         if (rx_cnt < MAXB) rx_got[rx_cnt] = rx_data;
         rx_cnt = rx_cnt + 1;
      end
      if (done) begin
         done_cnt = done_cnt + 1;
         done_cyc = cyc;
      end
      if (!cs_n) cs_lo_seen = 1;
      if (sclk && !sclk_q) begin
         mcur  = {mcur[6:0], mosi};
         mbits = mbits + 1;
         if ((mbits % 8) == 0 && (mbits / 8) <= MAXB) mosi_got[mbits/8 - 1] = mcur;
      end
      if (!cs_n && cs_q) begin
         sbit = 0;
         miso = rxpat(cur_seed, 0)[7];
      end else if (!cs_n && !sclk && sclk_q) begin
         sbit = sbit + 1;
         miso = rxpat(cur_seed, sbit / 8)[7 - (sbit % 8)];
      end
      if (tgt_en) begin
         if (tgt_ph == 0 && !wake_oe) begin
            tgt_cnt = tgt_cnt + 1;
            if (tgt_cnt >= tgt_delay) begin
               tgt_drive = 1'b1; tgt_ph = 1; tgt_cnt = 0;
            end
         end else if (tgt_ph == 1) begin
            if (!cs_n) saw_cs = 1'b1;
            if (saw_cs && cs_n) begin
               tgt_cnt = tgt_cnt + 1;
               if (tgt_cnt >= tgt_hold) begin
                  tgt_drive = 1'b0; tgt_ph = 2; rel_cyc = cyc;
               end
            end
         end
      end
      sclk_q = sclk;
      cs_q   = cs_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic clear_mon(input logic [7:0] s);
      cur_seed = s; tx_k = 0; rx_cnt = 0; mbits = 0; done_cnt = 0; done_cyc = 0;
      cs_lo_seen = 0; rel_cyc = 0; mcur = '0;
      tgt_ph = 0; tgt_cnt = 0; tgt_drive = 1'b0; saw_cs = 1'b0;
   endtask

   // mode 0: normal, 1: extra start while busy, 2: line low before request
   task automatic run_xfer(input int tl, input int rl, input logic [7:0] s, input int mode);
      int nb, bad6, bad7, bad8, st;
      nb = (tl > rl) ? tl : rl;
      clear_mon(s);
      tgt_en = (mode != 2); pre_low = (mode == 2);
      tx_len = LW'(tl); rx_len = LW'(rl); start = 1'b1;
      step();
      start = 1'b0;
      chk(busy && !wake_oe && cs_n, "R2", "busy/release/cs after start",
          {busy, wake_oe, cs_n}, 3'b101);
      if (mode == 2) begin
         repeat (30) step();
         chk(cs_n && busy, "R3", "cs while line held low", cs_n, 1);
         pre_low = 1'b0;
         repeat (30) step();
         chk(cs_n && busy, "R3", "cs while line only high", cs_n, 1);
         tgt_ph = 0; tgt_cnt = 0; tgt_delay = 2; tgt_en = 1'b1;
      end
      st = 0;
      while (done_cnt == 0 && st < 20000) begin
         if (mode == 1 && st == 60) begin start = 1'b1; tx_len = 4'd2; end
         else start = 1'b0;
         step();
         st++;
      end
      start = 1'b0; tx_len = LW'(tl);
      bad6 = 0; bad7 = 0; bad8 = 0;
      for (int i = 0; i < nb; i++) begin
         if (i < tl && mosi_got[i] != txpat(s, i)) bad6++;
         if (i >= tl && mosi_got[i] != 8'hFF) bad7++;
      end
      for (int i = 0; i < rl && i < rx_cnt; i++)
         if (rx_got[i] != rxpat(s, i)) bad8++;
      chk(mbits == 8 * nb, "R9", "bits clocked", mbits, 8 * nb);
      chk(tx_k == tl, "R6", "tx_take pulses", tx_k, tl);
      chk(bad6 == 0, "R6", "tx bytes on mosi (MSB first, R5)", bad6, 0);
      chk(bad7 == 0, "R7", "filler bytes on mosi", bad7, 0);
      chk(rx_cnt == rl, "R8", "rx_valid pulses", rx_cnt, rl);
      chk(bad8 == 0, "R8", "rx bytes (MSB first, R5)", bad8, 0);
      chk(done_cnt == 1 && !timeout_err, "R10", "done once, no error",
          done_cnt, 1);
      chk(done_cyc > rel_cyc + 1, "R10", "done after target release", done_cyc, rel_cyc + 2);
      repeat (6) step();
      chk(!busy && wake_oe && cs_n && done_cnt == 1, "R11", "idle after done",
          {busy, wake_oe, cs_n}, 3'b011);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      clear_mon(8'h00);
      repeat (3) step();
      // R1 reset state
      chk(wake_oe && cs_n && !sclk && !busy && !done, "R1", "reset outputs",
          {wake_oe, cs_n, sclk, busy, done}, 5'b11000);
      rst_n = 1'b1;
      repeat (2) step();
      // R9 zero-length request ignored
      tx_len = '0; rx_len = '0; start = 1'b1;
      step();
      start = 1'b0;
      step();
      chk(!busy && wake_oe, "R9", "zero-length start ignored", busy, 0);

      // vector table
      for (int v = 0; v < 6; v++)
         run_xfer(int'(VECS[v][15:12]), int'(VECS[v][11:8]), VECS[v][7:0], 0);

      // R11 start while busy
      run_xfer(3, 3, 8'h6B, 1);
      // R3 line already low when released
      run_xfer(1, 1, 8'h2E, 2);

      // R4 timeout with silent target
      clear_mon(8'h11);
      tgt_en = 1'b0; pre_low = 1'b0;
      tx_len = 4'd2; rx_len = 4'd2; start = 1'b1;
      begin
         int sc;
         sc = cyc;
         step();
         start = 1'b0;
         for (int k = 0; k < WL + 50 && done_cnt == 0; k++) step();
         chk(done_cnt == 1 && timeout_err, "R4", "timeout done with error",
             {done_cnt, timeout_err}, 3);
         chk(done_cyc - sc >= WL && done_cyc - sc <= WL + 2, "R4", "timeout cycle",
             done_cyc - sc, WL + 1);
         chk(cs_lo_seen == 0 && wake_oe && !busy, "R4", "no cs, line driven",
             cs_lo_seen, 0);
      end
      tgt_delay = 5;
      run_xfer(2, 3, 8'h77, 0);
      chk(!timeout_err, "R4", "error cleared by next start", timeout_err, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule